// File: doc/BRIEF.md
# Serial Control Port for a Multi-Clock Generator

This block is the control front end of an audio clock generator. A host writes 16-bit frames over three wires: a frame-enable line that is active low, a bit clock, and a data line. All three are synchronised into the master-clock domain, and every register in the block runs on that one clock. The six most significant bits of a frame are a header. The header selects either the mode register or the configuration register. A frame with any other header is dropped.

The mode register holds six per-output clock enables, a sample-rate code and a frequency-group code. The configuration register holds one bit that chooses the output range of the selectable clock. That bit is combined with an external range pin to form a 2-bit range select. When every clock enable is cleared, the block asserts power-down. The serial port still accepts frames in that state, so the host can resume operation with a later write.

After reset, an initialisation counter holds both registers at their defaults for a fixed number of master-clock cycles. Frames that arrive during that window are not stored. Reserved rate or group codes are stored exactly as written, and they set a sticky flag.

Top module: `clkgen_serial_ctrl`

## Requirements
- R1: For INIT_CYCLES (1024) master-clock cycles after reset release, `init_busy` is 1, the registers hold their defaults, and frames sent in that window have no effect. `init_busy` then falls and stays low until the next reset.
- R2: A frame is shifted in MSB first. The data line is sampled on each rising edge of the bit clock while the frame-enable line is low. A rising edge of the frame-enable line commits the frame.
- R3: A frame whose bits 15..10 are 011100 writes the mode register. Bits 9..4 go to `clk_en[5:0]`, bits 3..2 go to `rate_code`, and bits 1..0 go to `group_code`.
- R4: A frame whose bits 15..10 are 011011 writes bit 4 to the configuration bit, provided bits 9..5 and 3..0 are all 0. Otherwise the frame is ignored. A configuration write leaves the mode register unchanged.
- R5: A frame whose header matches neither pattern changes no output.
- R6: A frame is discarded when the frame-enable line rises after fewer or more than 16 bit-clock rising edges. The next correct frame is still accepted.
- R7: `range_sel` is {configuration bit, `range_pin`}. The codes are 00 = 36.864 MHz, 01 = 24.576 MHz, 10 = 18.432 MHz and 11 = 12.288 MHz.
- R8: `pwr_down` is 1 exactly while all six clock enables are 0. A later mode frame that sets any enable clears it.
- R9: A rate code of 11 or a group code of 11 is stored as written and sets `bad_code`. `bad_code` stays set until reset.
- R10: The defaults are `clk_en`=111111, `rate_code`=00 (standard), `group_code`=00 (48 kHz group), configuration bit 0, and `bad_code` 0. Rate codes are 01 double and 10 half. Group codes are 01 for 44.1 kHz and 10 for 32 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Frame enable, low while bits are shifted |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data, MSB first |
| range_pin | input | 1 | External range select pin |
| clk_en | output | 6 | Per-output clock enables |
| rate_code | output | 2 | Sample-rate code |
| group_code | output | 2 | Frequency-group code |
| range_sel | output | 2 | Selectable-clock range code |
| pwr_down | output | 1 | All enables cleared |
| init_busy | output | 1 | Initialisation window active |
| bad_code | output | 1 | Sticky reserved-code flag |

## Verification
The bench sends frames with 15 and with 17 bits. A design that counted edges loosely would store a shifted word there and corrupt the enables. It also sends frames with a header that differs from a valid one in a single bit, and a configuration frame with a reserved bit set. Either of these must leave every output unchanged. It writes all enables to zero, then writes them back. This exposes a port that locks up in power-down or a flag that never clears. It also writes during the initialisation window and checks that the sticky flag survives later valid writes. This catches early writes that leak into the registers and a flag that clears itself.

// File: rtl/clkgen_ctrl_pkg.sv
package clkgen_ctrl_pkg;
  localparam int FRAME_W = 16;
  localparam int HDR_W   = 6;
  localparam int EN_W    = 6;
  localparam logic [HDR_W-1:0] HDR_MODE = 6'b011100;
  localparam logic [HDR_W-1:0] HDR_CFG  = 6'b011011;
  localparam logic [EN_W-1:0]  EN_DEFAULT = '1;

  typedef enum logic [1:0] {
    RATE_STD  = 2'b00,
    RATE_DBL  = 2'b01,
    RATE_HALF = 2'b10,
    RATE_RSVD = 2'b11
  } rate_t;

  typedef enum logic [1:0] {
    GRP_48K  = 2'b00,
    GRP_44K1 = 2'b01,
    GRP_32K  = 2'b10,
    GRP_RSVD = 2'b11
  } group_t;
endpackage

// File: rtl/ctrl_sync.sv
module ctrl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ctrl_frame_shifter.sv
module ctrl_frame_shifter
  import clkgen_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_n,
  input  logic               bclk,
  input  logic               dat,
  output logic               frame_stb,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             sel_q, bclk_q;
  logic             sel_rise, bclk_rise;
  logic [CNT_W-1:0] bit_cnt;

  assign sel_rise  = sel_n & ~sel_q;
  assign bclk_rise = bclk & ~bclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= 1'b1;
      bclk_q     <= 1'b0;
      bit_cnt    <= '0;
      frame_stb  <= 1'b0;
      frame_word <= '0;
    end else begin
      sel_q     <= sel_n;
      bclk_q    <= bclk;
      frame_stb <= 1'b0;
      if (sel_rise) begin
        frame_stb <= (bit_cnt == CNT_W'(FRAME_W));
        bit_cnt   <= '0;
      end else if (bclk_rise && !sel_n) begin
        frame_word <= {frame_word[FRAME_W-2:0], dat};
        if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  p_count_sat_r6: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(CNT_MAX));
  p_stb_len_r6: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> ($past(bit_cnt) == CNT_W'(FRAME_W)));
  p_stb_on_sel_rise_r2: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> $past(sel_rise));
endmodule

// File: rtl/ctrl_init_timer.sv
module ctrl_init_timer #(
  parameter int INIT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic busy
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(INIT_CYCLES - 1)) busy <= 1'b0;
    end
  end

  p_busy_stays_low_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);
endmodule

// File: rtl/clkgen_serial_ctrl.sv
module clkgen_serial_ctrl
  import clkgen_ctrl_pkg::*;
#(
  parameter int INIT_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_sel_n,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       range_pin,
  output logic [5:0] clk_en,
  output logic [1:0] rate_code,
  output logic [1:0] group_code,
  output logic [1:0] range_sel,
  output logic       pwr_down,
  output logic       init_busy,
  output logic       bad_code
);
  logic [3:0]         pins_s;
  logic               stb;
  logic [FRAME_W-1:0] word;
  logic               cfg_bit;
  logic [HDR_W-1:0]   hdr;
  logic               cfg_rsvd_clear;
  logic               code_bad;

  ctrl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({range_pin, ser_dat, ser_clk, ser_sel_n}),
    .sync_out(pins_s)
  );

  ctrl_frame_shifter u_shift (
    .clk(clk), .rst(rst),
    .sel_n(pins_s[0]), .bclk(pins_s[1]), .dat(pins_s[2]),
    .frame_stb(stb), .frame_word(word)
  );

  ctrl_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst(rst), .busy(init_busy)
  );

  assign hdr            = word[FRAME_W-1 -: HDR_W];
  assign cfg_rsvd_clear = ~|{word[9:5], word[3:0]};
  assign code_bad       = (word[3:2] == RATE_RSVD) || (word[1:0] == GRP_RSVD);

  always_ff @(posedge clk) begin
    if (rst || init_busy) begin
      clk_en     <= EN_DEFAULT;
      rate_code  <= RATE_STD;
      group_code <= GRP_48K;
      cfg_bit    <= 1'b0;
    end else if (stb) begin
      if (hdr == HDR_MODE) begin
        clk_en     <= word[9:4];
        rate_code  <= word[3:2];
        group_code <= word[1:0];
      end else if (hdr == HDR_CFG && cfg_rsvd_clear) begin
        cfg_bit <= word[4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_code  <= 1'b0;
      pwr_down  <= 1'b0;
      range_sel <= 2'b00;
    end else begin
      if (!init_busy && stb && hdr == HDR_MODE && code_bad) bad_code <= 1'b1;
      pwr_down  <= (clk_en == '0);
      range_sel <= {cfg_bit, pins_s[3]};
    end
  end

  p_bad_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    bad_code |=> bad_code);
  p_defaults_in_init_r1: assert property (@(posedge clk) disable iff (rst)
    $past(init_busy) |-> (clk_en == EN_DEFAULT && rate_code == 2'b00 && group_code == 2'b00));
  p_hold_without_frame_r5: assert property (@(posedge clk) disable iff (rst)
    (!stb && !init_busy) |=> ($stable(clk_en) && $stable(rate_code) && $stable(group_code)));
  p_pd_follows_enables_r8: assert property (@(posedge clk) disable iff (rst)
    (!init_busy && $stable(clk_en)) |=> (pwr_down == ($past(clk_en) == '0)));
endmodule

// File: tb/clkgen_serial_ctrl_test.sv
module clkgen_serial_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_N = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0, range_pin = 1'b0;
  logic [5:0] clk_en;
  logic [1:0] rate_code, group_code, range_sel;
  logic pwr_down, init_busy, bad_code;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_serial_ctrl uut (
    .clk(clk), .rst(rst), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .range_pin(range_pin), .clk_en(clk_en),
    .rate_code(rate_code), .group_code(group_code), .range_sel(range_sel),
    .pwr_down(pwr_down), .init_busy(init_busy), .bad_code(bad_code)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    ser_sel_n = 1'b0;
    cycles(4);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 16) ? w[15-i] : 1'b0;
      cycles(4);
      ser_clk = 1'b1;
      cycles(4);
      ser_clk = 1'b0;
    end
    cycles(4);
    ser_sel_n = 1'b1;
    cycles(10);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_init();
    do_reset();
    chk("R1 busy after reset", {7'd0, init_busy}, 8'd1);
    send({6'b011100, 6'b000000, 2'b01, 2'b10}, 16);
    chk("R1 frame in init ignored", {2'd0, clk_en}, 8'h3F);
    chk("R1 busy still high", {7'd0, init_busy}, 8'd1);
    cycles(INIT_N);
    chk("R1 busy low", {7'd0, init_busy}, 8'd0);
    chk("R10 default enables", {2'd0, clk_en}, 8'h3F);
    chk("R10 default rate", {6'd0, rate_code}, 8'd0);
    chk("R10 default group", {6'd0, group_code}, 8'd0);
    chk("R10 default range", {6'd0, range_sel}, 8'd0);
    chk("R10 default pwr", {7'd0, pwr_down}, 8'd0);
    chk("R10 default bad", {7'd0, bad_code}, 8'd0);
  endtask

  task automatic t_mode();
    send({6'b011100, 6'b101010, 2'b01, 2'b10}, 16);
    chk("R3 enables A", {2'd0, clk_en}, 8'h2A);
    chk("R2 rate A", {6'd0, rate_code}, 8'd1);
    chk("R3 group A", {6'd0, group_code}, 8'd2);
    send({6'b011100, 6'b010101, 2'b10, 2'b01}, 16);
    chk("R3 enables B", {2'd0, clk_en}, 8'h15);
    chk("R2 rate B", {6'd0, rate_code}, 8'd2);
    chk("R3 group B", {6'd0, group_code}, 8'd1);
  endtask

  task automatic t_cfg();
    send({6'b011011, 5'b00000, 1'b1, 4'b0000}, 16);
    chk("R7 cfg1 pin0", {6'd0, range_sel}, 8'd2);
    chk("R4 mode unchanged", {2'd0, clk_en}, 8'h15);
    range_pin = 1'b1;
    cycles(6);
    chk("R7 cfg1 pin1", {6'd0, range_sel}, 8'd3);
    send({6'b011011, 5'b00100, 1'b0, 4'b0000}, 16);
    chk("R4 reserved bit frame ignored", {6'd0, range_sel}, 8'd3);
    send({6'b011011, 5'b00000, 1'b0, 4'b0000}, 16);
    chk("R7 cfg0 pin1", {6'd0, range_sel}, 8'd1);
    range_pin = 1'b0;
    cycles(6);
    chk("R7 cfg0 pin0", {6'd0, range_sel}, 8'd0);
  endtask

  task automatic t_bad_header();
    send({6'b011101, 6'b000000, 2'b00, 2'b00}, 16);
    chk("R5 bad header enables", {2'd0, clk_en}, 8'h15);
    chk("R5 bad header rate", {6'd0, rate_code}, 8'd2);
    send({6'b111011, 5'b00000, 1'b1, 4'b0000}, 16);
    chk("R5 bad header range", {6'd0, range_sel}, 8'd0);
  endtask

  task automatic t_count();
    send({6'b011100, 6'b000011, 2'b00, 2'b00}, 15);
    chk("R6 short frame", {2'd0, clk_en}, 8'h15);
    send({6'b011100, 6'b000011, 2'b00, 2'b00}, 17);
    chk("R6 long frame", {2'd0, clk_en}, 8'h15);
    send({6'b011100, 6'b110011, 2'b00, 2'b00}, 16);
    chk("R6 frame after discard", {2'd0, clk_en}, 8'h33);
  endtask

  task automatic t_pd();
    send({6'b011100, 6'b000000, 2'b00, 2'b00}, 16);
    chk("R8 power down", {7'd0, pwr_down}, 8'd1);
    send({6'b011100, 6'b000001, 2'b00, 2'b00}, 16);
    chk("R8 resume", {7'd0, pwr_down}, 8'd0);
    chk("R8 enables resumed", {2'd0, clk_en}, 8'h01);
  endtask

  task automatic t_reserved();
    send({6'b011100, 6'b111111, 2'b00, 2'b11}, 16);
    chk("R9 reserved group stored", {6'd0, group_code}, 8'd3);
    chk("R9 flag set", {7'd0, bad_code}, 8'd1);
    send({6'b011100, 6'b111111, 2'b00, 2'b00}, 16);
    chk("R9 flag sticky", {7'd0, bad_code}, 8'd1);
    send({6'b011100, 6'b111111, 2'b11, 2'b00}, 16);
    chk("R9 reserved rate stored", {6'd0, rate_code}, 8'd3);
    do_reset();
    chk("R9 flag cleared by reset", {7'd0, bad_code}, 8'd0);
    cycles(INIT_N);
    chk("R10 rate after reset", {6'd0, rate_code}, 8'd0);
  endtask

  initial begin
    cycles(2);
    t_init();
    t_mode();
    t_cfg();
    t_bad_header();
    t_count();
    t_pd();
    t_reserved();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule